// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Core

This block holds the tag, address and data state of a set-associative data cache. It answers lookups and allocates lines. Each request carries a virtual address and its physical address. A combinational lookup searches only the set picked by the virtual address and reports hit or miss, the way that matched, and the addressed data word of that way. A request that hits can also replace one 32-bit word of the cached line. Address translation is done outside the block. The caller presents both addresses together.

On a miss the caller pulses an allocate strobe. A multi-cycle engine takes the victim way from that set's round-robin pointer. Its first step depends on the mode. In write-back mode, a valid victim is first copied word by word to the physical line it came from. The engine then refills the line from the new physical line, one 32-bit word per memory acknowledge. Last, it records the line-aligned virtual tag with a valid flag and stores the physical line address for a later write-back. In write-through mode the engine only records the tag and the physical address. A parameter selects the mode. The line size, the number of ways and the number of sets are also parameters; the number of sets and the number of ways must be powers of two. Coherence and byte merging are not handled here.

Top module: `cache_core`

## Requirements
- R1: After reset every line is invalid, so every lookup misses; busy_o and mem_req_o are low.
- R2: hit_o is high only when a valid line in the indexed set holds a tag equal to req_vaddr_i[31:OFF] (OFF = log2 of the line size in bytes); hit_way_o then names that way. hit_o is held low while busy_o is high.
- R3: The set index is req_vaddr_i[OFF +: log2(SETS)]. Lines whose addresses differ only above those bits share a set.
- R4: Each set has its own victim pointer, reset to way 0. Every accepted allocation uses the pointer's way and advances the pointer by one. After way WAYS-1 it returns to 0.
- R5: In write-back mode a valid victim is written back before the refill. There is one memory write (mem_we_o=1) per word, at the stored physical line address plus 4*word, in ascending order, carrying the words the line holds.
- R6: In write-back mode the refill reads words 0 to WORDS-1 in ascending order, starting at the line-aligned req_paddr_i. A word is stored only in a cycle where mem_ack_i is high.
- R7: At the end of an allocation the line holds the line-aligned virtual tag with its valid flag set. A later lookup anywhere in that line hits. A later eviction of the line writes to the stored physical line.
- R8: In write-through mode an allocation makes no memory request. busy_o is high for exactly the one cycle after acceptance, and the line hits afterwards.
- R9: An allocation is accepted when alloc_i is high while busy_o is low. busy_o is then high until it completes, and done_o is high for exactly its last cycle. alloc_i is ignored while busy_o is high.
- R10: While mem_req_o is high and mem_ack_i is low, mem_addr_o, mem_we_o and mem_wdata_o hold their values.
- R11: When hit_o is high, rd_data_o is word req_vaddr_i[OFF-1:2] of the hit way. If wr_i is also high, that word takes wr_data_i at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vaddr_i | input | 32 | Virtual address for lookup and allocation |
| req_paddr_i | input | 32 | Physical address that goes with req_vaddr_i |
| alloc_i | input | 1 | Start allocating the line of the request |
| wr_i | input | 1 | Write wr_data_i into the hit word |
| wr_data_i | input | 32 | Word to store on a hit write |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | WAY_W | Way that hit |
| rd_data_o | output | 32 | Addressed word of the hit line, zero on a miss |
| busy_o | output | 1 | Allocation in progress |
| done_o | output | 1 | Last cycle of an allocation |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge, completes one word |

## Verification
The bench fills a single set past its way count. This shows whether the pointer wraps to way 0 and evicts the oldest line. A pointer shared across sets, or one that does not wrap, would report the wrong hit way or leave a stale line hitting. Acknowledges arrive after random delays, so a refill that stores a word without waiting for its acknowledge leaves wrong data in the line. A write-back sent to the new physical address, or in the wrong word order, makes the bench's copy of memory differ from the expected one. A strobe pulsed during a busy allocation must not start a second one; a write-through instance must finish in one cycle without touching memory.

// File: rtl/cache_core_pkg.sv
package cache_core_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } alloc_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [WAY_W-1:0] lk_way_o,
  input  logic             vic_take_i,
  output logic [WAY_W-1:0] vic_way_o,
  output logic             vic_valid_o,
  output logic [TAG_W-1:0] vic_ptag_o,
  input  logic             upd_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic [WAY_W-1:0] upd_way_i,
  input  logic [TAG_W-1:0] upd_vtag_i,
  input  logic [TAG_W-1:0] upd_ptag_i
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] vtag_q  [SETS][WAYS];
  logic [TAG_W-1:0] ptag_q  [SETS][WAYS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_q[lk_set_i][w] && (vtag_q[lk_set_i][w] == lk_tag_i);
  end

  always_comb begin
    lk_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) lk_way_o = WAY_W'(w);
    end
  end
  assign lk_hit_o = |match;

  // victim info is read from the lookup set at the acceptance cycle
  assign vic_way_o   = ptr_q[lk_set_i];
  assign vic_valid_o = valid_q[lk_set_i][ptr_q[lk_set_i]];
  assign vic_ptag_o  = ptag_q[lk_set_i][ptr_q[lk_set_i]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (vic_take_i) begin
        if (ptr_q[lk_set_i] == WAY_W'(WAYS - 1)) ptr_q[lk_set_i] <= '0;
        else ptr_q[lk_set_i] <= ptr_q[lk_set_i] + 1'b1;
      end
      if (upd_i) valid_q[upd_set_i][upd_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_i) begin
      vtag_q[upd_set_i][upd_way_i] <= upd_vtag_i;
      ptag_q[upd_set_i][upd_way_i] <= upd_ptag_i;
    end
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int WORDS = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2,
  parameter int WRD_W = 2
) (
  input  logic             clk_i,
  input  logic             fill_we_i,
  input  logic [SET_W-1:0] line_set_i,
  input  logic [WAY_W-1:0] line_way_i,
  input  logic [WRD_W-1:0] line_word_i,
  input  logic [31:0]      fill_data_i,
  output logic [31:0]      line_data_o,
  input  logic             hit_we_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [WRD_W-1:0] hit_word_i,
  input  logic [31:0]      hit_wdata_i,
  output logic [31:0]      hit_rdata_o
);
  localparam int DEPTH = SETS * WAYS * WORDS;

  logic [31:0] mem_q [DEPTH];

  function automatic int slot(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w,
                              input logic [WRD_W-1:0] d);
    return ((int'(s) * WAYS) + int'(w)) * WORDS + int'(d);
  endfunction

  assign line_data_o = mem_q[slot(line_set_i, line_way_i, line_word_i)];
  assign hit_rdata_o = mem_q[slot(hit_set_i, hit_way_i, hit_word_i)];

  always_ff @(posedge clk_i) begin
    if (fill_we_i) mem_q[slot(line_set_i, line_way_i, line_word_i)] <= fill_data_i;
    else if (hit_we_i) mem_q[slot(hit_set_i, hit_way_i, hit_word_i)] <= hit_wdata_i;
  end
endmodule

// File: rtl/cache_alloc_fsm.sv
module cache_alloc_fsm
  import cache_core_pkg::*;
#(
  parameter bit WRITE_BACK = 1'b1,
  parameter int WORDS      = 4,
  parameter int OFF_W      = 4,
  parameter int TAG_W      = 28,
  parameter int SET_W      = 2,
  parameter int WAY_W      = 2,
  parameter int WRD_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_vtag_i,
  input  logic [TAG_W-1:0] req_ptag_i,
  input  logic [WAY_W-1:0] vic_way_i,
  input  logic             vic_valid_i,
  input  logic [TAG_W-1:0] vic_ptag_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [SET_W-1:0] line_set_o,
  output logic [WAY_W-1:0] line_way_o,
  output logic [WRD_W-1:0] line_word_o,
  input  logic [31:0]      line_data_i,
  output logic             fill_we_o,
  output logic             upd_o,
  output logic [TAG_W-1:0] upd_vtag_o,
  output logic [TAG_W-1:0] upd_ptag_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i
);
  alloc_state_e     st_q, st_d;
  logic [SET_W-1:0] set_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] vtag_q, ptag_q, old_ptag_q;
  logic [WRD_W-1:0] cnt_q;
  logic             last_word;
  logic [TAG_W-1:0] base_tag;

  assign take_o    = (st_q == ST_IDLE) && alloc_i;
  assign last_word = (cnt_q == WRD_W'(WORDS - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (alloc_i) begin
        if (!WRITE_BACK) st_d = ST_DONE;
        else if (vic_valid_i) st_d = ST_EVICT;
        else st_d = ST_FILL;
      end
      ST_EVICT: if (mem_ack_i && last_word) st_d = ST_FILL;
      ST_FILL:  if (mem_ack_i && last_word) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      set_q      <= '0;
      way_q      <= '0;
      vtag_q     <= '0;
      ptag_q     <= '0;
      old_ptag_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_o) begin
        set_q      <= req_set_i;
        way_q      <= vic_way_i;
        vtag_q     <= req_vtag_i;
        ptag_q     <= req_ptag_i;
        old_ptag_q <= vic_ptag_i;
        cnt_q      <= '0;
      end else if (mem_req_o && mem_ack_i) begin
        cnt_q <= last_word ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign line_set_o  = set_q;
  assign line_way_o  = way_q;
  assign line_word_o = cnt_q;
  assign fill_we_o   = (st_q == ST_FILL) && mem_ack_i;
  assign upd_o       = done_o;
  assign upd_vtag_o  = vtag_q;
  assign upd_ptag_o  = ptag_q;

  assign base_tag    = (st_q == ST_EVICT) ? old_ptag_q : ptag_q;
  assign mem_req_o   = (st_q == ST_EVICT) || (st_q == ST_FILL);
  assign mem_we_o    = (st_q == ST_EVICT);
  assign mem_addr_o  = {base_tag, OFF_W'(0)} | (32'(cnt_q) << 2);
  assign mem_wdata_o = (st_q == ST_EVICT) ? line_data_i : 32'h0;
endmodule

// File: rtl/cache_core.sv
module cache_core #(
  parameter int  LINE_BYTES = 16,
  parameter int  WAYS       = 4,
  parameter int  SETS       = 4,
  parameter bit  WRITE_BACK = 1'b1,
  localparam int WORDS      = LINE_BYTES / 4,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int TAG_W      = 32 - OFF_W,
  localparam int SET_W      = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int WRD_W      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      req_vaddr_i,
  input  logic [31:0]      req_paddr_i,
  input  logic             alloc_i,
  input  logic             wr_i,
  input  logic [31:0]      wr_data_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [31:0]      rd_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [31:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ack_i
);
  logic [SET_W-1:0] req_set;
  logic [WRD_W-1:0] req_word;
  logic [TAG_W-1:0] req_vtag, req_ptag;
  logic             raw_hit;
  logic [WAY_W-1:0] raw_way;
  logic             take;
  logic [WAY_W-1:0] vic_way;
  logic             vic_valid;
  logic [TAG_W-1:0] vic_ptag;
  logic             upd;
  logic [TAG_W-1:0] upd_vtag, upd_ptag;
  logic [SET_W-1:0] line_set;
  logic [WAY_W-1:0] line_way;
  logic [WRD_W-1:0] line_word;
  logic [31:0]      line_data, hit_rdata;
  logic             fill_we;

  assign req_vtag = req_vaddr_i[31:OFF_W];
  assign req_ptag = req_paddr_i[31:OFF_W];

  if (SETS > 1) begin : g_set
    assign req_set = req_vaddr_i[OFF_W +: SET_W];
  end else begin : g_one_set
    assign req_set = '0;
  end

  if (WORDS > 1) begin : g_word
    assign req_word = req_vaddr_i[OFF_W-1:2];
  end else begin : g_one_word
    assign req_word = '0;
  end

  cache_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (req_set),
    .lk_tag_i   (req_vtag),
    .lk_hit_o   (raw_hit),
    .lk_way_o   (raw_way),
    .vic_take_i (take),
    .vic_way_o  (vic_way),
    .vic_valid_o(vic_valid),
    .vic_ptag_o (vic_ptag),
    .upd_i      (upd),
    .upd_set_i  (line_set),
    .upd_way_i  (line_way),
    .upd_vtag_i (upd_vtag),
    .upd_ptag_i (upd_ptag)
  );

  cache_alloc_fsm #(
    .WRITE_BACK(WRITE_BACK), .WORDS(WORDS), .OFF_W(OFF_W), .TAG_W(TAG_W),
    .SET_W(SET_W), .WAY_W(WAY_W), .WRD_W(WRD_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (alloc_i),
    .req_set_i  (req_set),
    .req_vtag_i (req_vtag),
    .req_ptag_i (req_ptag),
    .vic_way_i  (vic_way),
    .vic_valid_i(vic_valid),
    .vic_ptag_i (vic_ptag),
    .take_o     (take),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .line_set_o (line_set),
    .line_way_o (line_way),
    .line_word_o(line_word),
    .line_data_i(line_data),
    .fill_we_o  (fill_we),
    .upd_o      (upd),
    .upd_vtag_o (upd_vtag),
    .upd_ptag_o (upd_ptag),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ack_i  (mem_ack_i)
  );

  cache_data_store #(
    .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .SET_W(SET_W), .WAY_W(WAY_W), .WRD_W(WRD_W)
  ) u_data (
    .clk_i      (clk_i),
    .fill_we_i  (fill_we),
    .line_set_i (line_set),
    .line_way_i (line_way),
    .line_word_i(line_word),
    .fill_data_i(mem_rdata_i),
    .line_data_o(line_data),
    .hit_we_i   (wr_i && hit_o),
    .hit_set_i  (req_set),
    .hit_way_i  (raw_way),
    .hit_word_i (req_word),
    .hit_wdata_i(wr_data_i),
    .hit_rdata_o(hit_rdata)
  );

  // lines under refill keep their old tag valid, so lookups wait for idle
  assign hit_o     = raw_hit && !busy_o;
  assign hit_way_o = raw_way;
  assign rd_data_o = hit_o ? hit_rdata : 32'h0;
endmodule

// File: rtl/cache_core_chk.sv
module cache_core_chk #(
  parameter bit WRITE_BACK = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alloc_i,
  input logic        hit_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ack_i
);
  assert_accept_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !busy_o |=> busy_o);

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_hit_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !hit_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_wdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o));

  assert_req_in_alloc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o && !done_o);

  assert_wt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !WRITE_BACK |-> !mem_req_o);
endmodule

bind cache_core cache_core_chk #(.WRITE_BACK(WRITE_BACK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alloc_i    (alloc_i),
  .hit_o      (hit_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/cache_core_bench.sv
module cache_core_bench;
  localparam int NW = 4, NS = 4, NWD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0, paddr = '0, wr_data = '0;
  logic        alloc = 1'b0, wr = 1'b0;
  logic        hit, busy, done, mem_req, mem_we;
  logic [1:0]  hit_way;
  logic [31:0] rd_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic        wt_alloc = 1'b0;
  logic        wt_hit, wt_busy, wt_done, wt_req, wt_we;
  logic [1:0]  wt_way;
  logic [31:0] wt_rd, wt_addr, wt_wdata;
  int          wt_req_seen = 0;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cache_core u_cache_core (
    .clk_i(clk), .rst_ni(rst_n), .req_vaddr_i(vaddr), .req_paddr_i(paddr),
    .alloc_i(alloc), .wr_i(wr), .wr_data_i(wr_data), .hit_o(hit), .hit_way_o(hit_way),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  cache_core #(.WRITE_BACK(1'b0)) u_cache_core_wt (
    .clk_i(clk), .rst_ni(rst_n), .req_vaddr_i(vaddr), .req_paddr_i(paddr),
    .alloc_i(wt_alloc), .wr_i(1'b0), .wr_data_i(32'h0), .hit_o(wt_hit), .hit_way_o(wt_way),
    .rd_data_o(wt_rd), .busy_o(wt_busy), .done_o(wt_done), .mem_req_o(wt_req),
    .mem_we_o(wt_we), .mem_addr_o(wt_addr), .mem_wdata_o(wt_wdata),
    .mem_rdata_i(32'h0), .mem_ack_i(1'b0)
  );

  // memory seen by the design, and the expected copy
  logic [31:0] mem   [1024];
  logic [31:0] x_mem [1024];

  // reference cache state
  bit          m_valid [NS][NW];
  int          m_vline [NS][NW];
  int          m_pline [NS][NW];
  int          m_ptr   [NS];
  logic [31:0] m_data  [NS][NW][NWD];

  always @(negedge clk) begin
    if (wt_req) wt_req_seen++;
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && ($urandom % 3 != 0)) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int set_of(input logic [31:0] va);
    return int'(va[5:4]);
  endfunction

  function automatic int find_way(input logic [31:0] va);
    int s = set_of(va);
    for (int w = 0; w < NW; w++)
      if (m_valid[s][w] && m_vline[s][w] == int'(va[31:4])) return w;
    return -1;
  endfunction

  task automatic set_req(input logic [31:0] va);
    vaddr = va;
    paddr = va + 32'h800;
  endtask

  task automatic look(input logic [31:0] va, input string tag);
    int ew;
    @(negedge clk);
    set_req(va);
    #2;
    ew = find_way(va);
    chk(hit == (ew >= 0), {tag, " hit"}, 32'(hit), 32'(ew >= 0));
    if (ew >= 0 && hit) begin
      chk(hit_way == 2'(ew), {tag, " way"}, 32'(hit_way), 32'(ew));
      chk(rd_data == m_data[set_of(va)][ew][va[3:2]], {tag, " R11 data"}, rd_data,
          m_data[set_of(va)][ew][va[3:2]]);
    end
  endtask

  task automatic write_word(input logic [31:0] va, input logic [31:0] d);
    int ew = find_way(va);
    @(negedge clk);
    set_req(va);
    wr = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1 wr = 1'b0;
    if (ew >= 0) m_data[set_of(va)][ew][va[3:2]] = d;
  endtask

  task automatic allocate(input logic [31:0] va, input bit intrude, input logic [31:0] other);
    int s, w, n_done, guard;
    bit mem_ok;
    @(negedge clk);
    set_req(va);
    alloc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    alloc = 1'b0;
    n_done = 0;
    guard = 0;
    if (intrude) begin
      set_req(other);
      alloc = 1'b1;
    end
    while (busy && guard < 500) begin
      if (done) n_done++;
      @(negedge clk);
      alloc = 1'b0;
      guard++;
    end
    set_req(va);
    chk(n_done == 1, "R9 done pulses", 32'(n_done), 32'd1);
    s = set_of(va);
    w = m_ptr[s];
    m_ptr[s] = (w + 1) % NW;
    if (m_valid[s][w])
      for (int k = 0; k < NWD; k++) x_mem[(m_pline[s][w] * 4 + k) % 1024] = m_data[s][w][k];
    for (int k = 0; k < NWD; k++) m_data[s][w][k] = x_mem[(int'(paddr[31:4]) * 4 + k) % 1024];
    m_valid[s][w] = 1'b1;
    m_vline[s][w] = int'(va[31:4]);
    m_pline[s][w] = int'(paddr[31:4]);
    mem_ok = 1'b1;
    for (int i = 0; i < 1024; i++) if (mem[i] !== x_mem[i]) mem_ok = 1'b0;
    chk(mem_ok, "R5 write-back memory image", 32'(mem_ok), 32'd1);
  endtask

  task automatic run_all();
    logic [31:0] va;
    int n;
    for (int i = 0; i < 1024; i++) begin
      mem[i]   = (32'(i) * 32'h9E37) ^ 32'hC0DE0000;
      x_mem[i] = mem[i];
    end
    for (int s = 0; s < NS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < NW; w++) m_valid[s][w] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all lines invalid after reset
    for (int k = 0; k < 6; k++) look(32'(k * 52), "R1 reset");
    chk(!busy && !mem_req, "R1 idle", {30'd0, busy, mem_req}, 32'd0);

    // R4/R3: five lines into set 0, pointer wraps and evicts way 0
    for (int k = 0; k < 5; k++) begin
      allocate(32'(k * 64), 1'b0, 32'h0);
      look(32'(k * 64 + 4), "R4 R7 round robin");
    end
    look(32'h0, "R4 wrapped victim gone");
    allocate(32'h10, 1'b0, 32'h0);
    look(32'h1C, "R3 other set way0");

    // R11 + R5: dirty a line, then force it out
    write_word(32'h48, 32'hDEAD_BEEF);
    look(32'h48, "R11 written");
    for (int k = 0; k < 4; k++) allocate(32'h8 + 32'(k * 64 + 256), 1'b0, 32'h0);
    look(32'h48, "R5 evicted");

    // R9: strobe during a busy allocation is ignored
    allocate(32'h3A0, 1'b1, 32'h3E0);
    look(32'h3A0, "R9 first line");
    look(32'h3E0, "R9 intruder ignored");

    // random traffic
    for (int i = 0; i < 250; i++) begin
      va = 32'(($urandom % 64) * 16 + ($urandom % 4) * 4);
      look(va, "R2 R6 random");
      if (find_way(va) >= 0) begin
        if ($urandom % 3 == 0) write_word(va, $urandom);
      end else begin
        allocate(va, 1'b0, 32'h0);
      end
    end

    // R8: write-through instance
    @(negedge clk);
    set_req(32'h120);
    #2;
    chk(!wt_hit, "R8 wt miss before", 32'(wt_hit), 32'd0);
    @(negedge clk);
    wt_alloc = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wt_alloc = 1'b0;
    n = 0;
    while (wt_busy && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk(n == 1, "R8 wt busy cycles", 32'(n), 32'd1);
    #2;
    chk(wt_hit, "R8 wt hit after", 32'(wt_hit), 32'd1);
    chk(wt_req_seen == 0, "R8 wt no memory traffic", 32'(wt_req_seen), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule